// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block keeps the operating state of a CAN protocol controller: whether it is held in reset mode, whether it only listens, and whether it sleeps. A host writes a three-bit mode word; the block also watches the bus-off event from the error logic, the bit-time tick and sampled receive bit from the bit-timing logic, and two interrupt-related inputs. From these it produces the enables that the rest of the controller obeys: bus-on, acknowledge, error-counter freeze, transmit inhibit, receive enable, oscillator and clock-output enables, and a one-cycle wake-up interrupt pulse.

Rejoining the bus after reset mode is cleared is gated by counting bus-free sequences (eleven recessive bit ticks in a row). The number of sequences needed depends on what caused the reset. Sleep is entered only when the bus is idle and no interrupt is outstanding. The clock output keeps running for a fixed number of bit times after sleep starts. Three different events end sleep.

The mode word and the other inputs are control signals that are sampled every cycle. There is no data stream, so there is no back-pressure, and a write is always accepted in the cycle it is presented.

Top module: `can_mode_seq`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 3'b001 (bit 0 reset mode, bit 1 listen-only, bit 2 sleep). `bus_on_o` and `rx_en_o` are 0. `tx_inhibit_o`, `err_freeze_o`, `osc_en_o` and `clkout_en_o` are 1, and `wake_irq_o` is 0.
- R2: A `bus_off_i` pulse sets `mode_o[0]` at the next clock edge. In the same cycle, `bus_on_o` and `rx_en_o` drop and `tx_inhibit_o` rises, which aborts any transfer in progress.
- R3: A host write of `wr_data_i[0]` is first held as a request. It reaches `mode_o[0]` on an internal half-rate clock phase, so it is visible no later than two clock edges after the write edge.
- R4: After a hardware or host-initiated reset, clearing reset mode gives `bus_on_o`=1 once a single bus-free sequence has completed: 11 consecutive `bit_tick_i` cycles with `rx_bit_i`=1. A tick with `rx_bit_i`=0 restarts the run.
- R5: After a reset caused by bus-off, `bus_on_o` rises only after 128 bus-free sequences. A host write with `wr_data_i[0]`=1 made while not in reset mode selects the single-sequence rule again.
- R6: `wr_data_i[1]` (listen-only) is stored only by a write made while `mode_o[0]`=1. At any other time the bit is ignored and `mode_o[1]` keeps its value.
- R7: With listen-only set, `ack_en_o`=0, `err_freeze_o`=1 and `tx_inhibit_o`=1, even while bus-on with `rx_en_o`=1.
- R8: A write of `wr_data_i[2]`=1 outside reset mode puts the block to sleep at the next edge only if a bus-free sequence has been seen since the last dominant tick, `irq_pend_i`=0 and `int_n_i`=1. If any of these fails, `mode_o[2]` stays 0 and `wake_irq_o` pulses for one cycle.
- R9: On sleep entry, `osc_en_o` drops at once. `clkout_en_o` stays 1 until 15 bit ticks have elapsed in sleep, then drops.
- R10: Sleep ends at the next edge on any of three events: a host write with `wr_data_i[2]`=0, `rx_bit_i`=0, or `int_n_i`=0. Wake-up restores `osc_en_o` and `clkout_en_o` and pulses `wake_irq_o`.
- R11: After a wake-up caused by bus activity, `rx_en_o` stays 0 until a full bus-free sequence of 11 recessive ticks completes.
- R12: A sleep request written while in reset mode is ignored, with no wake-up pulse. After reset mode is cleared, a sleep request fails as in R8 until a bus-free sequence has been seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| wr_en_i | input | 1 | Host mode-word write strobe |
| wr_data_i | input | 3 | Mode word: [0] reset, [1] listen-only, [2] sleep |
| bus_off_i | input | 1 | Bus-off event pulse from the error logic |
| bit_tick_i | input | 1 | One-cycle pulse per bit time, at the sample point |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| irq_pend_i | input | 1 | An interrupt is pending |
| int_n_i | input | 1 | External interrupt line, active low |
| mode_o | output | 3 | Synchronized mode word, same field layout as the write |
| bus_on_o | output | 1 | Controller takes part in bus traffic |
| ack_en_o | output | 1 | Acknowledge slot may be driven |
| err_freeze_o | output | 1 | Error counters hold their values |
| tx_inhibit_o | output | 1 | Transmission blocked |
| osc_en_o | output | 1 | Oscillator enable |
| clkout_en_o | output | 1 | Clock output enable |
| rx_en_o | output | 1 | Reception enabled |
| wake_irq_o | output | 1 | One-cycle wake-up interrupt |

## Verification
Every result except the reset bit appears at the first clock edge after its stimulus. This includes bus-off, listen-only and sleep stores, wake-up, bus-on after the closing recessive tick, and the clock-output cut after the fifteenth tick. The bench drives inputs on the falling edge and samples on the following falling edge. A reset-bit write may take up to two edges because of the half-rate phase, so the bench lets three falling edges pass before reading `mode_o[0]`. Bus-free sequences are driven one tick every two cycles. The bench checks the output on the falling edge after the tick that should complete or fail a sequence, and again one tick earlier.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int MODE_W    = 3;
  localparam int MB_RESET  = 0;
  localparam int MB_LISTEN = 1;
  localparam int MB_SLEEP  = 2;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_HOST = 2'd1,
    WK_BUS  = 2'd2,
    WK_LINE = 2'd3
  } wake_src_e;
endpackage

// File: rtl/can_rm_sync.sv
module can_rm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  logic wr_reset_i,
  input  logic wr_listen_i,
  input  logic bus_off_i,
  output logic rm_o,
  output logic lom_o,
  output logic long_wait_o
);
  logic ph_q, req_q, rm_q, lom_q, cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= 1'b0;
      req_q   <= 1'b1;
      rm_q    <= 1'b1;
      lom_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      if (bus_off_i) begin
        req_q   <= 1'b1;
        rm_q    <= 1'b1;
        cause_q <= 1'b1;
      end else begin
        if (wr_en_i) begin
          req_q <= wr_reset_i;
          if (wr_reset_i && !rm_q) cause_q <= 1'b0;
        end
        if (ph_q) rm_q <= req_q;
      end
      if (wr_en_i && rm_q && !bus_off_i) lom_q <= wr_listen_i;
    end
  end

  assign rm_o        = rm_q;
  assign lom_o       = lom_q;
  assign long_wait_o = cause_q;

  // R2
  busoff_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_i |=> rm_q);
  // R6
  lom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rm_q |=> $stable(lom_q));
  // R3
  rm_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rm_q) && !$past(bus_off_i)) |-> $past(ph_q));
endmodule

// File: rtl/can_busfree.sv
module can_busfree #(
  parameter int RUN_LEN   = 11,
  parameter int SEQ_SHORT = 1,
  parameter int SEQ_LONG  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rm_i,
  input  logic long_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic bf_pulse_o,
  output logic idle_o,
  output logic bus_on_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int SEQ_W = $clog2(SEQ_LONG + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;
  logic [SEQ_W-1:0] seq_q, need;
  logic             idle_q, bf;

  generate
    if (SEQ_SHORT == SEQ_LONG) begin : g_fixed_need
      assign need = SEQ_W'(SEQ_LONG);
      logic unused_long;
      assign unused_long = long_i;
    end else begin : g_sel_need
      assign need = long_i ? SEQ_W'(SEQ_LONG) : SEQ_W'(SEQ_SHORT);
    end
  endgenerate

  assign bf = !rm_i && tick_i && rx_i && (run_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seq_q  <= '0;
      idle_q <= 1'b0;
    end else if (rm_i) begin
      run_q  <= '0;
      seq_q  <= '0;
      idle_q <= 1'b0;
    end else if (tick_i) begin
      if (!rx_i) begin
        run_q  <= '0;
        idle_q <= 1'b0;
      end else if (bf) begin
        run_q  <= '0;
        idle_q <= 1'b1;
        if (seq_q < need) seq_q <= seq_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign bf_pulse_o = bf;
  assign idle_o     = idle_q;
  assign bus_on_o   = !rm_i && (seq_q >= need);

  // R4
  dom_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !rx_i) |=> !idle_q);
  // R4
  buson_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_on_o) && !$past(rm_i)) |-> $past(bf));
endmodule

// File: rtl/can_sleep_ctl.sv
module can_sleep_ctl
  import can_mode_pkg::*;
#(
  parameter int LINGER = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rm_i,
  input  logic idle_i,
  input  logic bf_i,
  input  logic tick_i,
  input  logic rx_i,
  input  logic irq_pend_i,
  input  logic int_n_i,
  input  logic wr_en_i,
  input  logic wr_sleep_i,
  output logic sleep_o,
  output logic osc_en_o,
  output logic clkout_en_o,
  output logic rx_block_o,
  output logic wake_irq_o
);
  localparam int LIN_W = $clog2(LINGER + 1);
  localparam logic [LIN_W-1:0] LIN_MAX = LIN_W'(LINGER);

  logic [LIN_W-1:0] lin_q;
  logic             sleep_q, block_q, wake_q;
  logic             enter_req, enter_ok;
  wake_src_e        src;

  always_comb begin
    src = WK_NONE;
    if (sleep_q && !rm_i) begin
      if (wr_en_i && !wr_sleep_i) src = WK_HOST;
      else if (!rx_i)             src = WK_BUS;
      else if (!int_n_i)          src = WK_LINE;
    end
  end

  assign enter_req = wr_en_i && wr_sleep_i && !sleep_q && !rm_i;
  assign enter_ok  = idle_i && !irq_pend_i && int_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      block_q <= 1'b0;
      wake_q  <= 1'b0;
      lin_q   <= '0;
    end else if (rm_i) begin
      sleep_q <= 1'b0;
      block_q <= 1'b0;
      wake_q  <= 1'b0;
      lin_q   <= '0;
    end else begin
      wake_q <= (src != WK_NONE) || (enter_req && !enter_ok);
      if (src != WK_NONE)          sleep_q <= 1'b0;
      else if (enter_req && enter_ok) sleep_q <= 1'b1;
      if (src == WK_BUS) block_q <= 1'b1;
      else if (bf_i)     block_q <= 1'b0;
      if (!sleep_q)                    lin_q <= '0;
      else if (tick_i && lin_q < LIN_MAX) lin_q <= lin_q + 1'b1;
    end
  end

  assign sleep_o     = sleep_q;
  assign osc_en_o    = !sleep_q;
  assign clkout_en_o = !sleep_q || (lin_q < LIN_MAX);
  assign rx_block_o  = block_q;
  assign wake_irq_o  = wake_q;

  // R8
  sleep_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> $past(idle_i && !irq_pend_i && int_n_i));
  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep_q) && !$past(rm_i)) |-> wake_q);
  // R9
  clkout_linger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> clkout_en_o);
  // R12
  no_sleep_in_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rm_i) |-> !$rose(sleep_q));
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN   = 11,
  parameter int SEQ_SHORT = 1,
  parameter int SEQ_LONG  = 128,
  parameter int LINGER    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  input  logic              bus_off_i,
  input  logic              bit_tick_i,
  input  logic              rx_bit_i,
  input  logic              irq_pend_i,
  input  logic              int_n_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              bus_on_o,
  output logic              ack_en_o,
  output logic              err_freeze_o,
  output logic              tx_inhibit_o,
  output logic              osc_en_o,
  output logic              clkout_en_o,
  output logic              rx_en_o,
  output logic              wake_irq_o
);
  logic rm, lom, long_wait, bf, idle, bus_on, sleep, rx_block;

  can_rm_sync u_rm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_reset_i  (wr_data_i[MB_RESET]),
    .wr_listen_i (wr_data_i[MB_LISTEN]),
    .bus_off_i   (bus_off_i),
    .rm_o        (rm),
    .lom_o       (lom),
    .long_wait_o (long_wait)
  );

  can_busfree #(
    .RUN_LEN   (RUN_LEN),
    .SEQ_SHORT (SEQ_SHORT),
    .SEQ_LONG  (SEQ_LONG)
  ) u_bf (
    .clk        (clk),
    .rst_n      (rst_n),
    .rm_i       (rm),
    .long_i     (long_wait),
    .tick_i     (bit_tick_i),
    .rx_i       (rx_bit_i),
    .bf_pulse_o (bf),
    .idle_o     (idle),
    .bus_on_o   (bus_on)
  );

  can_sleep_ctl #(.LINGER(LINGER)) u_sleep (
    .clk         (clk),
    .rst_n       (rst_n),
    .rm_i        (rm),
    .idle_i      (idle),
    .bf_i        (bf),
    .tick_i      (bit_tick_i),
    .rx_i        (rx_bit_i),
    .irq_pend_i  (irq_pend_i),
    .int_n_i     (int_n_i),
    .wr_en_i     (wr_en_i),
    .wr_sleep_i  (wr_data_i[MB_SLEEP]),
    .sleep_o     (sleep),
    .osc_en_o    (osc_en_o),
    .clkout_en_o (clkout_en_o),
    .rx_block_o  (rx_block),
    .wake_irq_o  (wake_irq_o)
  );

  always_comb begin
    mode_o            = '0;
    mode_o[MB_RESET]  = rm;
    mode_o[MB_LISTEN] = lom;
    mode_o[MB_SLEEP]  = sleep;
  end

  assign bus_on_o     = bus_on;
  assign rx_en_o      = bus_on && !sleep && !rx_block;
  assign ack_en_o     = rx_en_o && !lom;
  assign err_freeze_o = rm || lom;
  assign tx_inhibit_o = !bus_on || lom || sleep;

  // R2
  busoff_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_i |=> (!bus_on_o && !rx_en_o && tx_inhibit_o));
  // R7
  listen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[MB_LISTEN] |-> (!ack_en_o && tx_inhibit_o));
endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_data_i = 3'b000;
  logic       bus_off_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       rx_bit_i = 1'b1;
  logic       irq_pend_i = 1'b0;
  logic       int_n_i = 1'b1;
  logic [2:0] mode_o;
  logic       bus_on_o, ack_en_o, err_freeze_o, tx_inhibit_o;
  logic       osc_en_o, clkout_en_o, rx_en_o, wake_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .bus_off_i(bus_off_i), .bit_tick_i(bit_tick_i), .rx_bit_i(rx_bit_i),
    .irq_pend_i(irq_pend_i), .int_n_i(int_n_i), .mode_o(mode_o),
    .bus_on_o(bus_on_o), .ack_en_o(ack_en_o), .err_freeze_o(err_freeze_o),
    .tx_inhibit_o(tx_inhibit_o), .osc_en_o(osc_en_o),
    .clkout_en_o(clkout_en_o), .rx_en_o(rx_en_o), .wake_irq_o(wake_irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic host_wr_sync(input logic [2:0] d);
    host_wr(d);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      bit_tick_i = 1'b1; rx_bit_i = v;
      @(negedge clk);
      bit_tick_i = 1'b0; rx_bit_i = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 3'b001);
    chk("R1 bus_on", bus_on_o, 0);
    chk("R1 rx_en", rx_en_o, 0);
    chk("R1 tx_inhibit", tx_inhibit_o, 1);
    chk("R1 err_freeze", err_freeze_o, 1);
    chk("R1 osc/clkout", {osc_en_o, clkout_en_o}, 2'b11);
    chk("R1 wake", wake_irq_o, 0);
  endtask

  task automatic t_leave_reset();
    host_wr_sync(3'b000);
    chk("R3 reset bit cleared", mode_o, 3'b000);
    chk("R4 still off", bus_on_o, 0);
    send_bits(10, 1'b1); send_bits(1, 1'b0); send_bits(10, 1'b1);
    chk("R4 dominant restarts run", bus_on_o, 0);
    send_bits(1, 1'b1);
    chk("R4 bus on", bus_on_o, 1);
    chk("R4 rx/ack", {rx_en_o, ack_en_o}, 2'b11);
    chk("R4 tx/freeze", {tx_inhibit_o, err_freeze_o}, 2'b00);
  endtask

  task automatic t_lom_ignored();
    host_wr_sync(3'b010);
    chk("R6 listen ignored", mode_o, 3'b000);
    chk("R6 ack kept", ack_en_o, 1);
  endtask

  task automatic t_lom();
    host_wr_sync(3'b001);
    chk("R3 reset bit set", mode_o, 3'b001);
    host_wr_sync(3'b010);
    chk("R6 listen stored", mode_o, 3'b010);
    send_bits(11, 1'b1);
    chk("R4 host reset one seq", bus_on_o, 1);
    chk("R7 rx on", rx_en_o, 1);
    chk("R7 no ack", ack_en_o, 0);
    chk("R7 freeze/inhibit", {err_freeze_o, tx_inhibit_o}, 2'b11);
    host_wr_sync(3'b011);
    host_wr_sync(3'b000);
    send_bits(11, 1'b1);
    chk("R7 listen cleared", {mode_o, ack_en_o, tx_inhibit_o}, 5'b00010);
  endtask

  task automatic t_busoff();
    @(negedge clk); bus_off_i = 1'b1;
    @(negedge clk); bus_off_i = 1'b0;
    chk("R2 reset bit", mode_o[0], 1);
    chk("R2 abort", {bus_on_o, rx_en_o, tx_inhibit_o}, 3'b001);
    host_wr_sync(3'b000);
    chk("R3 cleared after busoff", mode_o[0], 0);
    send_bits(127 * 11, 1'b1);
    chk("R5 127 seqs not enough", bus_on_o, 0);
    send_bits(11, 1'b1);
    chk("R5 128 seqs bus on", bus_on_o, 1);
  endtask

  task automatic t_sleep_reject();
    irq_pend_i = 1'b1;
    host_wr(3'b100);
    chk("R8 irq pending wake", {mode_o[2], wake_irq_o}, 2'b01);
    @(negedge clk);
    chk("R8 wake one cycle", wake_irq_o, 0);
    irq_pend_i = 1'b0; int_n_i = 1'b0;
    host_wr(3'b100);
    chk("R8 line low wake", {mode_o[2], wake_irq_o}, 2'b01);
    int_n_i = 1'b1;
    send_bits(1, 1'b0);
    host_wr(3'b100);
    chk("R8 bus busy wake", {mode_o[2], wake_irq_o}, 2'b01);
    send_bits(11, 1'b1);
  endtask

  task automatic t_sleep_host();
    host_wr(3'b100);
    chk("R8 sleep entered", {mode_o[2], wake_irq_o}, 2'b10);
    chk("R9 osc off", osc_en_o, 0);
    send_bits(14, 1'b1);
    chk("R9 clkout lingers", clkout_en_o, 1);
    send_bits(1, 1'b1);
    chk("R9 clkout stops", clkout_en_o, 0);
    host_wr(3'b000);
    chk("R10 host wake", {mode_o[2], wake_irq_o, osc_en_o, clkout_en_o}, 4'b0111);
    chk("R10 rx back", rx_en_o, 1);
  endtask

  task automatic t_wake_line();
    host_wr(3'b100);
    chk("R10 asleep", mode_o[2], 1);
    @(negedge clk); int_n_i = 1'b0;
    @(negedge clk); int_n_i = 1'b1;
    chk("R10 line wake", {mode_o[2], wake_irq_o, osc_en_o}, 3'b011);
  endtask

  task automatic t_wake_bus();
    host_wr(3'b100);
    chk("R10 asleep again", mode_o[2], 1);
    send_bits(1, 1'b0);
    chk("R10 bus wake", {mode_o[2], osc_en_o}, 2'b01);
    chk("R11 rx blocked", rx_en_o, 0);
    send_bits(10, 1'b1);
    chk("R11 still blocked", rx_en_o, 0);
    send_bits(1, 1'b1);
    chk("R11 rx resumes", rx_en_o, 1);
  endtask

  task automatic t_sleep_in_reset();
    host_wr_sync(3'b001);
    host_wr(3'b101);
    chk("R12 sleep in reset ignored", {mode_o[2], wake_irq_o, osc_en_o}, 3'b001);
    host_wr_sync(3'b100);
    chk("R12 left reset awake", mode_o, 3'b000);
    host_wr(3'b100);
    chk("R12 no bus-free yet", {mode_o[2], wake_irq_o}, 2'b01);
    send_bits(11, 1'b1);
    chk("R4 host reset single seq", bus_on_o, 1);
    host_wr(3'b100);
    chk("R12 sleep after bus-free", mode_o[2], 1);
    host_wr(3'b000);
    chk("R10 final wake", mode_o[2], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_leave_reset();
    t_lom_ignored();
    t_lom();
    t_busoff();
    t_sleep_reject();
    t_sleep_host();
    t_wake_line();
    t_wake_bus();
    t_sleep_in_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule